// File: doc/BRIEF.md
# Magic-Sequence Watchdog Timer

This block is a watchdog with a 32-bit register interface on the system clock and a timeout counter on a separate, slower watchdog clock. Software picks a power-of-two timeout through a delay code and sets an enable bit. It then keeps the system alive by writing two fixed key words to two registers, in order. A missed deadline, a wrong or misordered key, or a software reset request raises a one-cycle system reset request.

The block records why the last reset happened in a cause code. Only the power-on reset clears that code, so software can read it back after the system reset that the request triggered. Changes to the enable bit and the delay code are staged. The counter takes them up only at a valid refresh, or when the watchdog goes from off to on. Control moves into the watchdog clock domain through a toggle handshake. The expiry event comes back through a synchronized toggle.

Register offsets (byte address bits 3:2): 0x0 soft reset, 0x4 configuration, 0x8 key register A (reads return the cause), 0xC key register B.

Top module: `magic_watchdog`

## Requirements
- R1: After power-on reset the configuration reads 0, the cause reads 0 (hard reset), and no reset request is raised.
- R2: The configuration register at 0x4 holds the enable in bit 31 and the delay code in bits 4:0. It reads back the staged values, with all other bits 0. A read of 0x8 returns the cause in bits 2:0 and zeros above.
- R3: Once enabled with delay code d and not refreshed, the block raises the reset request about 2^(d+1) watchdog clock cycles later, plus synchronizer latency, and the cause becomes 1 (timeout).
- R4: A valid refresh is 0xABCD1234 written to 0x8 followed by 0x4321DCBA written to 0xC. It restarts the count, so refreshing more often than the timeout raises no request.
- R5: While the watchdog is active, a wrong key value, a write to 0xC without a pending 0x8 key, or a second key at 0x8 raises the request on the next cycle and sets cause 2 (bad refresh).
- R6: While the watchdog is inactive, wrong or misordered key writes raise no request and leave the cause unchanged.
- R7: Clearing the enable bit does not stop counting until a valid refresh follows. After that refresh, no timeout occurs.
- R8: A new delay code written while active has no effect on the running timeout until the next valid refresh.
- R9: Writing a value with bit 0 set to 0x0 raises the request on the next cycle and sets cause 3 (soft reset). Writing it with bit 0 clear does nothing.
- R10: A pulse on the user reset input sets cause 4 without raising a request.
- R11: The cause survives the system reset input. Only the power-on reset returns it to 0.
- R12: Each reset request produced by a timeout lasts exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (bus) clock |
| wdt_clk | input | 1 | Slow watchdog counting clock |
| por_n | input | 1 | Power-on reset, active low; also clears the cause |
| rst_n | input | 1 | System reset, active low; cause is kept |
| user_rst | input | 1 | User reset indication, one system cycle, records cause 4 |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Byte address bits 3:2 selecting the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register (combinational) |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with the default five-bit delay code, a two-stage synchronizer and a watchdog clock four times slower than the system clock. It uses delay codes from 3 to 6, which gives timeouts of 16 to 128 watchdog cycles. At those lengths, both the expiry and the staged-versus-applied delay can be measured against windows that allow for handshake latency. A seeded random phase mixes refresh spacing, delay codes and the ending (expiry or bad key) across several rounds.

// File: rtl/magic_watchdog_pkg.sv
package magic_watchdog_pkg;
    localparam int DATA_W = 32;
    localparam int EN_BIT = DATA_W - 1;
    localparam logic [DATA_W-1:0] KEY_A = 32'hABCD_1234;
    localparam logic [DATA_W-1:0] KEY_B = 32'h4321_DCBA;

    typedef enum logic [1:0] {
        W_SOFT = 2'd0,
        W_CFG  = 2'd1,
        W_KEYA = 2'd2,
        W_KEYB = 2'd3
    } word_e;

    typedef enum logic [2:0] {
        CAUSE_HARD   = 3'd0,
        CAUSE_EXPIRE = 3'd1,
        CAUSE_BADKEY = 3'd2,
        CAUSE_SOFT   = 3'd3,
        CAUSE_USER   = 3'd4
    } cause_e;
endpackage

// File: rtl/wdm_sync.sv
module wdm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/wdm_regs.sv
module wdm_regs
    import magic_watchdog_pkg::*;
#(
    parameter int DLY_W = 5
) (
    input  logic              clk,
    input  logic              rst_all_n,
    input  logic              por_n,
    input  logic              user_rst,
    input  logic              wr_en,
    input  logic [1:0]        word,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_s,
    input  logic              exp_s,
    output logic [DATA_W-1:0] rdata,
    output logic              ld_en,
    output logic [DLY_W-1:0]  ld_dly,
    output logic              req_t,
    output logic              sys_rst_req
);
    typedef struct packed {
        logic             cfg_en;
        logic [DLY_W-1:0] cfg_dly;
        logic             ld_en;
        logic [DLY_W-1:0] ld_dly;
        logic             act_en;
        logic             req_t;
        logic             pend;
        logic             seq1;
        logic             exp_seen;
        logic             pulse;
    } st_t;

    st_t    st_q, st_d;
    cause_e cause_q, cause_d;
    logic   soft_hit, bad_key, good_key, first_on, busy, exp_hit;

    always_comb begin
        st_d      = st_q;
        st_d.pulse = 1'b0;
        cause_d   = cause_q;
        soft_hit  = 1'b0;
        bad_key   = 1'b0;
        good_key  = 1'b0;
        first_on  = 1'b0;
        if (rst_all_n && wr_en) begin
            case (word_e'(word))
                W_SOFT: soft_hit = wdata[0];
                W_CFG: begin
                    st_d.cfg_en  = wdata[EN_BIT];
                    st_d.cfg_dly = wdata[DLY_W-1:0];
                    first_on     = wdata[EN_BIT] & ~st_q.act_en;
                end
                W_KEYA: begin
                    if (wdata == KEY_A && !st_q.seq1) begin
                        st_d.seq1 = 1'b1;
                    end else begin
                        st_d.seq1 = 1'b0;
                        bad_key   = st_q.act_en;
                    end
                end
                default: begin
                    st_d.seq1 = 1'b0;
                    if (st_q.seq1 && wdata == KEY_B) good_key = 1'b1;
                    else                             bad_key  = st_q.act_en;
                end
            endcase
        end
        busy = st_q.req_t ^ ack_s;
        if (good_key || first_on || st_q.pend) begin
            if (!busy) begin
                st_d.ld_en  = st_d.cfg_en;
                st_d.ld_dly = st_d.cfg_dly;
                st_d.act_en = st_d.cfg_en;
                st_d.req_t  = ~st_q.req_t;
                st_d.pend   = 1'b0;
            end else begin
                st_d.pend   = 1'b1;
            end
        end
        exp_hit       = rst_all_n && (exp_s ^ st_q.exp_seen);
        st_d.exp_seen = exp_s;
        st_d.pulse    = soft_hit | bad_key | exp_hit;
        if (soft_hit)      cause_d = CAUSE_SOFT;
        else if (bad_key)  cause_d = CAUSE_BADKEY;
        else if (exp_hit)  cause_d = CAUSE_EXPIRE;
        else if (user_rst) cause_d = CAUSE_USER;
    end

    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) st_q <= '0;
        else            st_q <= st_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cause_q <= CAUSE_HARD;
        else        cause_q <= cause_d;
    end

    always_comb begin
        rdata = '0;
        case (word_e'(word))
            W_CFG: begin
                rdata[EN_BIT]     = st_q.cfg_en;
                rdata[DLY_W-1:0]  = st_q.cfg_dly;
            end
            W_KEYA:  rdata[2:0] = cause_q;
            default: rdata = '0;
        endcase
    end

    assign ld_en       = st_q.ld_en;
    assign ld_dly      = st_q.ld_dly;
    assign req_t       = st_q.req_t;
    assign sys_rst_req = st_q.pulse;
endmodule

// File: rtl/wdm_counter.sv
module wdm_counter #(
    parameter int DLY_W = 5
) (
    input  logic             wclk,
    input  logic             wrst_n,
    input  logic             req_s,
    input  logic             ld_en,
    input  logic [DLY_W-1:0] ld_dly,
    output logic             ack_t,
    output logic             exp_t
);
    localparam int CNT_W = 2 ** DLY_W;
    localparam logic [DLY_W:0] TOP_SH = (DLY_W + 1)'(CNT_W - 1);

    typedef struct packed {
        logic             en;
        logic [DLY_W-1:0] dly;
        logic [CNT_W-1:0] cnt;
        logic             req_seen;
        logic             ack_t;
        logic             exp_t;
    } st_t;

    st_t              st_q, st_d;
    logic [DLY_W:0]   shamt;
    logic [CNT_W-1:0] last;

    always_comb begin
        st_d  = st_q;
        shamt = TOP_SH - {1'b0, st_q.dly};
        last  = {CNT_W{1'b1}} >> shamt;
        if (req_s != st_q.req_seen) begin
            st_d.req_seen = req_s;
            st_d.en       = ld_en;
            st_d.dly      = ld_dly;
            st_d.cnt      = '0;
            st_d.ack_t    = ~st_q.ack_t;
        end else if (st_q.en) begin
            if (st_q.cnt == last) begin
                st_d.cnt   = '0;
                st_d.exp_t = ~st_q.exp_t;
            end else begin
                st_d.cnt   = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ack_t = st_q.ack_t;
    assign exp_t = st_q.exp_t;
endmodule

// File: rtl/magic_watchdog.sv
module magic_watchdog
    import magic_watchdog_pkg::*;
#(
    parameter int DLY_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              wdt_clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              user_rst,
    input  logic              wr_en,
    input  logic [3:2]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sys_rst_req
);
    logic             rst_all_n;
    logic             req_t, req_s, ack_t, ack_s, exp_t, exp_s, ld_en;
    logic [DLY_W-1:0] ld_dly;

    assign rst_all_n = rst_n & por_n;

    wdm_regs #(.DLY_W(DLY_W)) u_regs (
        .clk(clk), .rst_all_n(rst_all_n), .por_n(por_n), .user_rst(user_rst),
        .wr_en(wr_en), .word(addr), .wdata(wdata), .ack_s(ack_s), .exp_s(exp_s),
        .rdata(rdata), .ld_en(ld_en), .ld_dly(ld_dly), .req_t(req_t),
        .sys_rst_req(sys_rst_req)
    );

    wdm_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(wdt_clk), .rst_n(rst_all_n), .d(req_t), .q(req_s)
    );
    wdm_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst_n(rst_all_n), .d(ack_t), .q(ack_s)
    );
    wdm_sync #(.STAGES(SYNC_STAGES)) u_exp_sync (
        .clk(clk), .rst_n(rst_all_n), .d(exp_t), .q(exp_s)
    );

    wdm_counter #(.DLY_W(DLY_W)) u_cnt (
        .wclk(wdt_clk), .wrst_n(rst_all_n), .req_s(req_s), .ld_en(ld_en),
        .ld_dly(ld_dly), .ack_t(ack_t), .exp_t(exp_t)
    );
endmodule

// File: rtl/magic_watchdog_chk.sv
module magic_watchdog_chk #(
    parameter int DLY_W = 5
) (
    input logic        clk,
    input logic        por_n,
    input logic        rst_n,
    input logic        user_rst,
    input logic        wr_en,
    input logic [3:2]  addr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        sys_rst_req
);
    localparam logic [31:0] CFG_MASK = 32'h8000_0000 | ((32'd1 << DLY_W) - 32'd1);

    AST_SOFT_REQUEST: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_en && addr == 2'd0 && wdata[0]) |=> (sys_rst_req && (addr != 2'd2 || rdata[2:0] == 3'd3))); // R9

    AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_en && addr == 2'd1) |=> (addr != 2'd1 || rdata == ($past(wdata) & CFG_MASK))); // R2

    AST_CAUSE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (addr == 2'd2) |-> (rdata[31:3] == '0)); // R2

    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (addr == 2'd2 && $past(addr == 2'd2) && !sys_rst_req && !$past(user_rst)) |-> $stable(rdata[2:0])); // R11

    AST_USER_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        ($past(user_rst) && !sys_rst_req && addr == 2'd2) |-> (rdata[2:0] == 3'd4)); // R10
endmodule

bind magic_watchdog magic_watchdog_chk #(.DLY_W(DLY_W)) i_chk (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .user_rst(user_rst), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .sys_rst_req(sys_rst_req)
);

// File: tb/test_magic_watchdog.sv
module test_magic_watchdog;
    logic        clk = 1'b0, wdt_clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0, user_rst = 1'b0, wr_en = 1'b0;
    logic [3:2]  addr = 2'd2;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sys_rst_req;

    int checks = 0, errors = 0, pulses = 0, wide = 0;
    logic prev_req = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always #8 wdt_clk = ~wdt_clk;

    magic_watchdog i_magic_watchdog (
        .clk(clk), .wdt_clk(wdt_clk), .por_n(por_n), .rst_n(rst_n),
        .user_rst(user_rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sys_rst_req(sys_rst_req)
    );

    always @(posedge clk) begin
        #1;
        if (sys_rst_req) begin
            pulses++;
            if (prev_req) wide++;
        end
        prev_req = sys_rst_req;
    end

    function automatic int win_lo(input int d);
        return 4 * (2 ** (d + 1)) - 6;
    endfunction
    function automatic int win_hi(input int d);
        return 4 * (2 ** (d + 1)) + 32;
    endfunction
    function automatic logic [31:0] cfg_word(input bit en, input int d);
        return {en, 26'd0, 5'(d)};
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd2;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic refresh();
        wr(2'd2, 32'hABCD_1234);
        wr(2'd3, 32'h4321_DCBA);
    endtask

    task automatic wait_pulse(input int max, output int n);
        int base;
        base = pulses;
        n = 0;
        while (pulses == base && n < max) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic sys_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_cause(input int exp, input string tag);
        logic [31:0] v;
        rd(2'd2, v);
        check(v == 32'(exp), tag, v, exp);
    endtask

    task automatic expect_timeout(input int d, input string tag);
        int n;
        wait_pulse(win_hi(d) + 20, n);
        check(n >= win_lo(d) && n <= win_hi(d), tag, n, 4 * (2 ** (d + 1)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n, base, d, k, iv;
        int unsigned seed_v;
        seed_v = $urandom(32'd1234);
        repeat (4) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R1 reset state
        rd(2'd1, v); check(v == 0, "R1 cfg after por", v, 0);
        check_cause(0, "R1 cause after por");
        check(pulses == 0, "R1 no request", pulses, 0);

        // R2 field layout
        wr(2'd1, 32'h7FFF_FFE5);
        rd(2'd1, v); check(v == 32'h5, "R2 cfg readback", v, 32'h5);
        rd(2'd0, v); check(v == 0, "R2 soft reads zero", v, 0);
        rd(2'd3, v); check(v == 0, "R2 keyB reads zero", v, 0);

        // R6 inactive: bad keys ignored
        base = pulses;
        wr(2'd3, 32'h4321_DCBA);
        wr(2'd2, 32'h0000_0001);
        repeat (3) @(negedge clk);
        check(pulses == base, "R6 no request while off", pulses, base);
        check_cause(0, "R6 cause unchanged");

        // R3 timeout, R12 width, R11 cause kept
        wr(2'd1, cfg_word(1, 3));
        base = pulses;
        expect_timeout(3, "R3 timeout delay 3");
        check(pulses == base + 1, "R3 one request", pulses, base + 1);
        repeat (2) @(negedge clk);
        check(wide == 0, "R12 one-cycle request", wide, 0);
        check_cause(1, "R3 cause timeout");
        sys_reset();
        check_cause(1, "R11 cause after system reset");

        // R4 refresh keeps alive
        wr(2'd1, cfg_word(1, 4));
        base = pulses;
        for (int i = 0; i < 5; i++) begin
            repeat (80) @(negedge clk);
            refresh();
        end
        check(pulses == base, "R4 refreshed no request", pulses, base);
        expect_timeout(4, "R4 timeout from last refresh");
        sys_reset();

        // R5 bad keys while active
        wr(2'd1, cfg_word(1, 5));
        base = pulses;
        wr(2'd3, 32'h4321_DCBA);
        check(pulses == base + 1, "R5 keyB without keyA", pulses, base + 1);
        check_cause(2, "R5 cause bad key order");
        sys_reset();
        wr(2'd1, cfg_word(1, 5));
        base = pulses;
        wr(2'd2, 32'h1234_5678);
        check(pulses == base + 1, "R5 wrong keyA value", pulses, base + 1);
        sys_reset();
        wr(2'd1, cfg_word(1, 5));
        base = pulses;
        wr(2'd2, 32'hABCD_1234);
        wr(2'd2, 32'hABCD_1234);
        check(pulses == base + 1, "R5 repeated keyA", pulses, base + 1);
        check_cause(2, "R5 cause repeated keyA");
        sys_reset();

        // R7 stop takes effect only after refresh
        wr(2'd1, cfg_word(1, 3));
        wr(2'd1, cfg_word(0, 3));
        expect_timeout(3, "R7 still counting after clear");
        check_cause(1, "R7 cause timeout");
        sys_reset();
        wr(2'd1, cfg_word(1, 3));
        wr(2'd1, cfg_word(0, 3));
        refresh();
        base = pulses;
        wait_pulse(400, n);
        check(pulses == base, "R7 stopped after refresh", pulses, base);
        sys_reset();

        // R8 staged delay
        wr(2'd1, cfg_word(1, 3));
        wr(2'd1, cfg_word(1, 6));
        expect_timeout(3, "R8 old delay still applied");
        sys_reset();
        wr(2'd1, cfg_word(1, 3));
        wr(2'd1, cfg_word(1, 6));
        refresh();
        expect_timeout(6, "R8 new delay after refresh");
        sys_reset();

        // R9 soft reset
        base = pulses;
        wr(2'd0, 32'hFFFF_FFFE);
        repeat (3) @(negedge clk);
        check(pulses == base, "R9 bit0 clear ignored", pulses, base);
        wr(2'd0, 32'h1);
        check(pulses == base + 1, "R9 soft request", pulses, base + 1);
        check_cause(3, "R9 cause soft");
        sys_reset();

        // R10 user reset
        base = pulses;
        @(negedge clk); user_rst = 1'b1;
        @(negedge clk); user_rst = 1'b0;
        check_cause(4, "R10 cause user");
        repeat (2) @(negedge clk);
        check(pulses == base, "R10 no request", pulses, base);

        // R11 power-on clears cause
        sys_reset();
        check_cause(4, "R11 kept over system reset");
        @(negedge clk); por_n = 1'b0;
        repeat (3) @(negedge clk); por_n = 1'b1;
        repeat (2) @(negedge clk);
        check_cause(0, "R11 cleared by power-on");

        // random rounds: R3 R4 R5
        for (int r = 0; r < 8; r++) begin
            d = 3 + int'($urandom % 3);
            k = 1 + int'($urandom % 4);
            wr(2'd1, cfg_word(1, d));
            base = pulses;
            for (int j = 0; j < k; j++) begin
                iv = 20 + int'($urandom % (2 * (2 ** (d + 1))));
                repeat (iv) @(negedge clk);
                refresh();
            end
            check(pulses == base, "R4 random refresh alive", pulses, base);
            if ($urandom % 2 == 0) begin
                expect_timeout(d, "R3 random timeout");
                check_cause(1, "R3 random cause");
            end else begin
                wr(2'd3, $urandom | 32'h1);
                check(pulses == base + 1, "R5 random bad key", pulses, base + 1);
                check_cause(2, "R5 random cause");
            end
            sys_reset();
        end
        check(wide == 0, "R12 no wide request", wide, 0);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule